// File: doc/BRIEF.md
# Split Increment/Decrement Correlation Accumulator

This block sums a stream of small signed correlator products over one code period and hands the total out when a dump strobe arrives. It suits correlators where the running sum drifts steadily in one direction, so the upper bits of the total change rarely.

Only the bottom three bits of the total go through a real adder. The thirteen upper bits sit in a chain of counter cells. These cells move by exactly one step up or down, and only when the low adder says the low field wrapped. A small encoder looks at the sign of each product and the carry of the low add. From these it decides whether the upper chain counts up, counts down or stays idle.

An increment or decrement enters at the lowest upper cell. It climbs only as far as the first cell that absorbs it. Above that cell, no bit toggles.

Top module: `incdec_accum`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is 0. A dump issued with no summands before it yields a result of 0.
- R2: The dumped result equals the two's-complement sum, modulo 2^16, of every valid summand accepted since the previous dump or reset. `in_sum` is a 3-bit two's-complement value (-4..3).
- R3: A valid summand of value zero or above makes the upper 13 bits step up by one exactly when adding its 3 bits to the low 3 bits, unsigned, produces a carry out.
- R4: A valid negative summand makes the upper 13 bits step down by one exactly when that 3-bit unsigned add produces no carry out.
- R5: In every other case, a summand leaves the upper 13 bits unchanged.
- R6: A step of the upper bits is exactly +1 or -1 modulo 2^13. It ripples through as many cells as needed, including a full wrap of all 16 bits.
- R7: A dump raises `out_valid` for exactly one cycle, on the cycle after the dump is sampled. `out_sum` carries the result as {upper 13 bits, lower 3 bits}, and the accumulator is cleared to zero.
- R8: A valid summand sampled in the same cycle as a dump is included in that dump's result. The next period starts from zero.
- R9: A summand with `in_valid` low has no effect on any later result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_sum` |
| in_sum | input | 3 | Two's-complement summand |
| dump | input | 1 | End-of-period strobe: output and clear the total |
| out_valid | output | 1 | One-cycle pulse marking a dumped result |
| out_sum | output | 16 | Dumped two's-complement total |

## Verification
Each start value from -9 to 9 is built up from summands. Every one of the eight summand codes is then applied and the total dumped. This sweep separates the carry-driven increment, the no-carry decrement and the idle case at every low-field position.

Two long runs test the ripple through all upper cells and the 16-bit wrap in both directions:
- a run of +3 summands that wraps the total upward;
- a short run of -4 summands that borrows across every upper cell.

Further dumps cover the following:
- a summand coinciding with a dump;
- invalid summands carrying nonzero data;
- back-to-back dumps.

// File: rtl/incdec_accum_pkg.sv
package incdec_accum_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_INC  = 2'd1,
    CMD_DEC  = 2'd2
  } step_cmd_e;
endpackage

// File: rtl/incdec_low_acc.sv
module incdec_low_acc #(
  parameter int LOW_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic [LOW_W-1:0] addend,
  output logic [LOW_W-1:0] q,
  output logic [LOW_W-1:0] q_next,
  output logic             carry
);
  logic [LOW_W:0] wide_sum;

  always_comb begin
    wide_sum = {1'b0, q} + {1'b0, addend};
    carry    = en & wide_sum[LOW_W];
    q_next   = en ? wide_sum[LOW_W-1:0] : q;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (en)    q <= wide_sum[LOW_W-1:0];
  end
endmodule

// File: rtl/incdec_encoder.sv
module incdec_encoder
  import incdec_accum_pkg::*;
(
  input  logic      valid,
  input  logic      negative,
  input  logic      carry,
  output step_cmd_e cmd
);
  always_comb begin
    cmd = CMD_NONE;
    if (valid) begin
      if (!negative && carry)     cmd = CMD_INC;
      else if (negative && !carry) cmd = CMD_DEC;
    end
  end
endmodule

// File: rtl/incdec_updown.sv
module incdec_updown
  import incdec_accum_pkg::*;
#(
  parameter int HIGH_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  step_cmd_e         cmd,
  output logic [HIGH_W-1:0] q,
  output logic [HIGH_W-1:0] q_next
);
  logic [HIGH_W-1:0] up_req;
  logic [HIGH_W-1:0] dn_req;

  assign up_req[0] = (cmd == CMD_INC);
  assign dn_req[0] = (cmd == CMD_DEC);

  for (genvar i = 0; i < HIGH_W; i++) begin : g_cell
    assign q_next[i] = q[i] ^ (up_req[i] | dn_req[i]);
    if (i < HIGH_W - 1) begin : g_pass
      assign up_req[i+1] = up_req[i] & q[i];
      assign dn_req[i+1] = dn_req[i] & ~q[i];
    end
    always_ff @(posedge clk) begin
      if (rst || clr) q[i] <= 1'b0;
      else if (up_req[i] || dn_req[i]) q[i] <= ~q[i];
    end
  end

  AST_INC_STEP: assert property (@(posedge clk) disable iff (rst)
    (!clr && cmd == CMD_INC) |=> (q == $past(q) + 1'b1)); // R6
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst)
    (!clr && cmd == CMD_DEC) |=> (q == $past(q) - 1'b1)); // R6
  AST_NOCMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clr && cmd == CMD_NONE) |=> $stable(q)); // R5
endmodule

// File: rtl/incdec_accum.sv
module incdec_accum
  import incdec_accum_pkg::*;
#(
  parameter int LOW_W  = 3,
  parameter int HIGH_W = 13,
  localparam int SUM_W = LOW_W + HIGH_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [LOW_W-1:0] in_sum,
  input  logic             dump,
  output logic             out_valid,
  output logic [SUM_W-1:0] out_sum
);
  logic [LOW_W-1:0]  low_q, low_next;
  logic              low_carry;
  logic [HIGH_W-1:0] high_q, high_next;
  step_cmd_e         step_cmd;

  incdec_low_acc #(.LOW_W(LOW_W)) low_i (
    .clk(clk), .rst(rst), .en(in_valid), .clr(dump),
    .addend(in_sum), .q(low_q), .q_next(low_next), .carry(low_carry)
  );

  incdec_encoder enc_i (
    .valid(in_valid), .negative(in_sum[LOW_W-1]),
    .carry(low_carry), .cmd(step_cmd)
  );

  incdec_updown #(.HIGH_W(HIGH_W)) high_i (
    .clk(clk), .rst(rst), .clr(dump), .cmd(step_cmd),
    .q(high_q), .q_next(high_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else begin
      out_valid <= dump;
      if (dump) out_sum <= {high_next, low_next};
    end
  end

  AST_POS_INC: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dump && !in_sum[LOW_W-1] && low_carry) |=> (high_q == $past(high_q) + 1'b1)); // R3
  AST_NEG_DEC: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dump && in_sum[LOW_W-1] && !low_carry) |=> (high_q == $past(high_q) - 1'b1)); // R4
  AST_DUMP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    dump |=> (low_q == '0 && high_q == '0 && out_valid)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !dump) |=> ($stable(low_q) && $stable(high_q) && !out_valid)); // R9
endmodule

// File: tb/incdec_accum_tb_top.sv
`timescale 1ns/1ps
module incdec_accum_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [2:0]  in_sum;
  logic        dump;
  logic        out_valid;
  logic [15:0] out_sum;

  int errors = 0;
  int checks = 0;
  int model  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  incdec_accum dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sum(in_sum),
    .dump(dump), .out_valid(out_valid), .out_sum(out_sum)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: drive on falling edge, look after the rising edge
  task automatic cyc(bit v, int s, bit d, string req);
    logic [15:0] exp;
    @(negedge clk);
    in_valid = v; in_sum = 3'(s); dump = d;
    if (v) model += s;
    exp = 16'(model);
    if (d) model = 0;
    @(posedge clk); #1;
    if (d) begin
      check(req, {31'd0, out_valid}, 32'd1);
      check(req, {16'd0, out_sum}, {16'd0, exp});
    end
  endtask

  task automatic preload(int p);
    int rem = p;
    while (rem > 3)  begin cyc(1, 3, 0, "R2");  rem -= 3; end
    while (rem < -4) begin cyc(1, -4, 0, "R2"); rem += 4; end
    if (rem != 0) cyc(1, rem, 0, "R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; in_valid = 0; in_sum = 0; dump = 0;
    repeat (3) @(posedge clk);
    #1 check("R1", {31'd0, out_valid}, 32'd0);
    @(negedge clk) rst = 0;
    cyc(0, 0, 1, "R1");

    // sweep: start value vs every summand code
    for (int p = -9; p <= 9; p++) begin
      for (int s = -4; s <= 3; s++) begin
        int lo;
        bit cy;
        string tag;
        lo = p & 7;
        cy = (lo + (s & 7)) > 7;
        if (s >= 0 && cy)     tag = "R3";
        else if (s < 0 && !cy) tag = "R4";
        else                  tag = "R5";
        preload(p);
        cyc(1, s, 1, tag);
      end
    end

    // R6: upward wrap of the full 16 bits through every upper cell
    for (int k = 0; k < 21846; k++) cyc(1, 3, 0, "R6");
    cyc(0, 0, 1, "R6");
    // R6: borrow through every upper cell
    cyc(1, -4, 0, "R6");
    cyc(1, -4, 1, "R6");

    // R8: summand with dump counts; next period from zero
    preload(5);
    cyc(1, 2, 1, "R8");
    cyc(1, 1, 1, "R8");

    // R9: invalid summands ignored
    preload(6);
    cyc(0, 3, 0, "R9");
    cyc(0, -4, 0, "R9");
    cyc(0, 3, 1, "R9");

    // R7: pulse lasts one cycle, sum cleared
    cyc(1, 2, 1, "R7");
    cyc(0, 0, 0, "R7");
    check("R7", {31'd0, out_valid}, 32'd0);
    cyc(0, 0, 1, "R7");

    // R2: mixed pattern
    for (int k = 0; k < 40; k++) cyc(1, (k % 8) - 4, 0, "R2");
    cyc(1, -3, 1, "R2");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule